// File: doc/BRIEF.md
# Indirect Table Memory Byte Window

This block gives a narrow 8-bit host access to a wide internal table memory through nine byte registers. The host stages a 24-bit word address and a 32-bit data word in byte registers. It then writes a command byte that starts one read or one write of a single-port synchronous table RAM. After that it polls a status byte until the access has finished. A read leaves the fetched word in the data registers, where the host reads it back byte by byte.

The host can send each register address with its byte. It can also name a start register once and then stream "continue" bytes, which fill the following registers in order. A single stream of one addressed byte and seven continue bytes stages the address and the data and issues the command. The table RAM model is part of the block. Software places a 96-bit entry n in three words starting at word address 3·n. The block itself attaches no meaning to the words.

Top module: `sram_window_port`

## Requirements
- R1: The register map has these byte addresses: 0x2001..0x2003 hold the word address, least significant byte at 0x2001. 0x2004..0x2007 hold the data word, least significant byte at 0x2004. 0x2008 is the command register and 0x2009 is the status register. Reading an address or data register returns the byte last written to it, unless a later read command has loaded the data registers.
- R2: Reads at any address below 0x2001 or above 0x2009 return 0x00. Writes at such addresses change no register and leave the stream pointer where it was.
- R3: An addressed write (host_wr) to register k loads the stream pointer with k+1. A continue write (host_cont) stores its byte in the register the pointer names and then advances the pointer. After reset the pointer names 0x2001.
- R4: The stream pointer stops at the command register 0x2008. Every further continue byte goes to the command register, and the pointer never wraps or reaches the status register.
- R5: Command 0x02 writes the staged data word to the staged word address. Word addresses at or above the table depth (64) lie outside the table: a write there stores nothing, and a read there returns zero.
- R6: Command 0x01 reads the word at the staged address. When the read finishes, the word is loaded into the four data registers in the same byte order as R1.
- R7: Status reads 0x01 when idle and 0x00 while an access is in progress. An accepted command makes status read 0x00 for exactly ACCESS_CYC+1 cycles (3 by default), starting the cycle after the write edge. A read result becomes visible in the same cycle that status returns to 0x01.
- R8: A command byte written while busy is ignored, as is any code other than 0x01 or 0x02. An ignored command starts no access and does not change the command register. The command register reads back the last accepted code.
- R9: Reset sets all address, data and command registers to 0x00, ends any access in progress and makes status read 0x01.
- R10: When host_wr and host_cont are both high, the addressed write takes effect and the continue strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host byte address for addressed writes and for reads |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Addressed write strobe, one byte per high cycle |
| host_cont | input | 1 | Continue write strobe, writes the register named by the stream pointer |
| host_rdata | output | 8 | Read byte for host_addr, combinational |

## Verification
The hardest situations to reach from the ports are a command arriving during the busy window and a stream pointer held at its limit. In both cases the stimulus must land in particular cycles, and the observable effect is indirect. The bench starts a read and writes a write command in the very next cycle. The write command would, if accepted, overwrite the table. So the bench later restages different data, reads the same word again, and shows that the table still holds the old value. For the pointer, a stream that runs past the data registers sends an invalid code and then a valid write code to the command register. The status going busy at once proves that the second byte did not wrap to the address registers.

// File: rtl/sram_win_pkg.sv
`timescale 1ns/1ps
// Shared constants for the byte window: register indices relative to the
// window base, command and status codes, and the command FSM state type.
package sram_win_pkg;
    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = 4;
    localparam int WORD_AW    = 8 * ADDR_BYTES;
    localparam int WORD_DW    = 8 * DATA_BYTES;
    localparam int NUM_REGS   = ADDR_BYTES + DATA_BYTES + 2;
    localparam int REG_IW     = 4;

    localparam logic [REG_IW-1:0] IDX_ADDR0 = '0;
    localparam logic [REG_IW-1:0] IDX_DATA0 = REG_IW'(ADDR_BYTES);
    localparam logic [REG_IW-1:0] IDX_CMD   = REG_IW'(ADDR_BYTES + DATA_BYTES);
    localparam logic [REG_IW-1:0] IDX_STAT  = REG_IW'(ADDR_BYTES + DATA_BYTES + 1);

    localparam logic [7:0] CMD_READ  = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] STAT_IDLE = 8'h01;
    localparam logic [7:0] STAT_BUSY = 8'h00;

    typedef enum logic {
        FSM_IDLE,
        FSM_BUSY
    } fsm_state_e;
endpackage

// File: rtl/win_decode.sv
`timescale 1ns/1ps
// Host address decoder and stream pointer.
// Turns an addressed write or a continue write into a register index, and
// keeps the pointer that continue writes use. The pointer saturates at the
// command register. Assumes that the window base plus NUM_REGS does not
// overflow HOST_AW bits.
module win_decode
    import sram_win_pkg::*;
#(
    parameter int                  HOST_AW   = 16,
    parameter logic [HOST_AW-1:0]  BASE_ADDR = 16'h2001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic                host_wr,
    input  logic                host_cont,
    output logic                wr_en,
    output logic [REG_IW-1:0]   wr_idx,
    output logic                rd_hit,
    output logic [REG_IW-1:0]   rd_idx,
    output logic [REG_IW-1:0]   ptr_q
);
    logic [HOST_AW-1:0] offset;
    logic               in_range;
    logic [REG_IW-1:0]  idx;

    // Advance an index by one, holding at the command register.
    function automatic logic [REG_IW-1:0] step(input logic [REG_IW-1:0] i);
        return (i >= IDX_CMD) ? IDX_CMD : i + REG_IW'(1);
    endfunction

    assign offset   = host_addr - BASE_ADDR;
    assign in_range = (host_addr >= BASE_ADDR) && (offset < HOST_AW'(NUM_REGS));
    assign idx      = offset[REG_IW-1:0];

    // An addressed write wins over a continue strobe in the same cycle.
    assign wr_en  = host_wr ? in_range : host_cont;
    assign wr_idx = host_wr ? idx : ptr_q;
    assign rd_hit = in_range;
    assign rd_idx = idx;

    // Stream pointer: reloaded by addressed writes, stepped by continue writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= IDX_ADDR0;
        end else if (host_wr) begin
            if (in_range) ptr_q <= step(idx);
        end else if (host_cont) begin
            ptr_q <= step(ptr_q);
        end
    end
endmodule

// File: rtl/win_stage.sv
`timescale 1ns/1ps
// Staging registers and the host read multiplexer.
// Holds the word address bytes, the data bytes and the last accepted
// command. It raises a one-cycle start request for a valid command that
// arrives while idle. A read result loads the data bytes and takes
// priority over a host write in the same cycle.
module win_stage
    import sram_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_IW-1:0]  wr_idx,
    input  logic [7:0]         wdata,
    input  logic               busy,
    input  logic               load_rd,
    input  logic [WORD_DW-1:0] rd_word,
    input  logic               rd_hit,
    input  logic [REG_IW-1:0]  rd_idx,
    output logic [WORD_AW-1:0] addr_word,
    output logic [WORD_DW-1:0] data_word,
    output logic [7:0]         cmd_q,
    output logic               start_rd,
    output logic               start_wr,
    output logic [7:0]         rd_byte
);
    logic [7:0] addr_b [ADDR_BYTES];
    logic [7:0] data_b [DATA_BYTES];
    logic       cmd_ok;

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_BYTES; gi++) begin : g_addr
            // One word-address byte, written by the host only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    addr_b[gi] <= '0;
                else if (wr_en && wr_idx == IDX_ADDR0 + REG_IW'(gi))
                    addr_b[gi] <= wdata;
            end
            assign addr_word[8*gi +: 8] = addr_b[gi];
        end
        for (gi = 0; gi < DATA_BYTES; gi++) begin : g_data
            // One data byte, loaded by a read result or by the host.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_b[gi] <= '0;
                else if (load_rd)
                    data_b[gi] <= rd_word[8*gi +: 8];
                else if (wr_en && wr_idx == IDX_DATA0 + REG_IW'(gi))
                    data_b[gi] <= wdata;
            end
            assign data_word[8*gi +: 8] = data_b[gi];
        end
    endgenerate

    assign cmd_ok   = wr_en && (wr_idx == IDX_CMD) && !busy;
    assign start_rd = cmd_ok && (wdata == CMD_READ);
    assign start_wr = cmd_ok && (wdata == CMD_WRITE);

    // Command register keeps the last accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (start_rd || start_wr)
            cmd_q <= wdata;
    end

    // Host read multiplexer; unmapped addresses read zero.
    always_comb begin
        rd_byte = '0;
        if (rd_hit) begin
            for (int i = 0; i < ADDR_BYTES; i++)
                if (rd_idx == IDX_ADDR0 + REG_IW'(i)) rd_byte = addr_b[i];
            for (int i = 0; i < DATA_BYTES; i++)
                if (rd_idx == IDX_DATA0 + REG_IW'(i)) rd_byte = data_b[i];
            if (rd_idx == IDX_CMD)  rd_byte = cmd_q;
            if (rd_idx == IDX_STAT) rd_byte = busy ? STAT_BUSY : STAT_IDLE;
        end
    end
endmodule

// File: rtl/win_cmd_fsm.sv
`timescale 1ns/1ps
// Command sequencer.
// On a start request it stays busy for ACCESS_CYC+1 cycles. In the first
// busy cycle it issues one RAM operation. In the last busy cycle it asks
// for a read result to be loaded. Assumes ACCESS_CYC >= 1, so the RAM
// output has settled before the load.
module win_cmd_fsm
    import sram_win_pkg::*;
#(
    parameter int ACCESS_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    output logic busy,
    output logic sram_we,
    output logic sram_re,
    output logic load_rd
);
    localparam int CW = $clog2(ACCESS_CYC + 1);

    fsm_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          rd_op_q;
    logic          last;

    assign last = (cnt_q == CW'(ACCESS_CYC));

    // State, cycle counter and operation kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
            cnt_q   <= '0;
            rd_op_q <= 1'b0;
        end else begin
            case (state_q)
                FSM_IDLE: if (start_rd || start_wr) begin
                    state_q <= FSM_BUSY;
                    cnt_q   <= '0;
                    rd_op_q <= start_rd;
                end
                FSM_BUSY: if (last) state_q <= FSM_IDLE;
                          else      cnt_q   <= cnt_q + CW'(1);
                default:  state_q <= FSM_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == FSM_BUSY);
    assign sram_we = busy && (cnt_q == '0) && !rd_op_q;
    assign sram_re = busy && (cnt_q == '0) && rd_op_q;
    assign load_rd = busy && last && rd_op_q;
endmodule

// File: rtl/win_table_ram.sv
`timescale 1ns/1ps
// Single-port synchronous table RAM model.
// Writes on the clock edge and registers read data on the clock edge.
// Addresses at or above DEPTH are outside the table: writes there are
// dropped and reads there return zero. The array itself has no reset.
module win_table_ram #(
    parameter int DEPTH = 64,
    parameter int AW_IN = 24,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW_IN-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          in_tbl;

    assign in_tbl = (addr < AW_IN'(DEPTH));

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (we && in_tbl) mem[addr[IW-1:0]] <= wdata;
        if (re)           rdata <= in_tbl ? mem[addr[IW-1:0]] : '0;
    end
endmodule

// File: rtl/sram_window_port.sv
`timescale 1ns/1ps
// Top of the indirect table-memory byte window.
// Connects the decoder, the staging registers, the command sequencer and
// the table RAM. Assumes the host waits for the idle status before it
// changes the staged address of an access in progress.
module sram_window_port
    import sram_win_pkg::*;
#(
    parameter int                 HOST_AW     = 16,
    parameter logic [HOST_AW-1:0] BASE_ADDR   = 16'h2001,
    parameter int                 TABLE_DEPTH = 64,
    parameter int                 ACCESS_CYC  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_wr,
    input  logic               host_cont,
    output logic [7:0]         host_rdata
);
    logic               wr_en, rd_hit;
    logic [REG_IW-1:0]  wr_idx, rd_idx, ptr_q;
    logic [WORD_AW-1:0] addr_word;
    logic [WORD_DW-1:0] data_word, ram_rdata;
    logic [7:0]         cmd_q;
    logic               start_rd, start_wr;
    logic               busy, sram_we, sram_re, load_rd;

    win_decode #(.HOST_AW(HOST_AW), .BASE_ADDR(BASE_ADDR)) u_decode (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_wr(host_wr), .host_cont(host_cont),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_hit(rd_hit),
        .rd_idx(rd_idx), .ptr_q(ptr_q)
    );

    win_stage u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wdata(host_wdata), .busy(busy), .load_rd(load_rd),
        .rd_word(ram_rdata), .rd_hit(rd_hit), .rd_idx(rd_idx),
        .addr_word(addr_word), .data_word(data_word), .cmd_q(cmd_q),
        .start_rd(start_rd), .start_wr(start_wr), .rd_byte(host_rdata)
    );

    win_cmd_fsm #(.ACCESS_CYC(ACCESS_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
        .busy(busy), .sram_we(sram_we), .sram_re(sram_re), .load_rd(load_rd)
    );

    win_table_ram #(.DEPTH(TABLE_DEPTH), .AW_IN(WORD_AW), .DW(WORD_DW)) u_ram (
        .clk(clk), .we(sram_we), .re(sram_re), .addr(addr_word),
        .wdata(data_word), .rdata(ram_rdata)
    );
endmodule

// File: rtl/win_checker.sv
`timescale 1ns/1ps
// Protocol checker for the byte window, attached to the top by bind.
module win_checker
    import sram_win_pkg::*;
#(
    parameter int                 HOST_AW    = 16,
    parameter logic [HOST_AW-1:0] BASE_ADDR  = 16'h2001,
    parameter int                 ACCESS_CYC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic [7:0]         host_wdata,
    input logic               host_wr,
    input logic [7:0]         host_rdata,
    input logic               busy,
    input logic [7:0]         cmd_q,
    input logic [REG_IW-1:0]  ptr_q,
    input logic               sram_we,
    input logic               sram_re
);
    localparam logic [HOST_AW-1:0] CMD_ADDR  = BASE_ADDR + HOST_AW'(IDX_CMD);
    localparam logic [HOST_AW-1:0] STAT_ADDR = BASE_ADDR + HOST_AW'(IDX_STAT);

    int run_q;

    // Length of the current busy run, counted in the checker.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr < BASE_ADDR || host_addr > STAT_ADDR) |-> host_rdata == 8'h00); // R2
    AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IDX_CMD); // R4
    AST_RAM_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_we, sram_re})); // R5
    AST_RAM_OP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we || sram_re) |-> busy); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == CMD_ADDR && !busy &&
         (host_wdata == CMD_READ || host_wdata == CMD_WRITE)) |=> busy); // R7
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q <= ACCESS_CYC); // R7
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == ACCESS_CYC + 1); // R7
    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == STAT_ADDR && !busy) |-> host_rdata == STAT_IDLE); // R7
    AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q)); // R8
endmodule

bind sram_window_port win_checker #(
    .HOST_AW(HOST_AW), .BASE_ADDR(BASE_ADDR), .ACCESS_CYC(ACCESS_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rdata(host_rdata), .busy(busy), .cmd_q(cmd_q),
    .ptr_q(ptr_q), .sram_we(sram_we), .sram_re(sram_re)
);

// File: tb/sram_window_port_tb.sv
`timescale 1ns/1ps
module sram_window_port_tb;
    localparam logic [15:0] A0 = 16'h2001, A1 = 16'h2002, A2 = 16'h2003;
    localparam logic [15:0] D0 = 16'h2004, D1 = 16'h2005, D3 = 16'h2007;
    localparam logic [15:0] CMD = 16'h2008, STAT = 16'h2009;
    localparam int NVEC = 8;
    // {word address, data word}; entry n starts at word 3n
    localparam logic [55:0] VEC [NVEC] = '{
        {24'h000000, 32'hA5A5_0001}, {24'h000001, 32'h0000_FFFF},
        {24'h000002, 32'h8000_0000}, {24'h000003, 32'h1234_5678},
        {24'h000004, 32'hDEAD_BEEF}, {24'h000005, 32'h0F0F_F0F0},
        {24'h00003C, 32'h7E57_0003}, {24'h00003F, 32'hCAFE_0042}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0, host_cont = 1'b0;
    logic [7:0]  host_rdata;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    sram_window_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_cont(host_cont), .host_rdata(host_rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1; host_cont = 1'b0;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cont_wr(input logic [7:0] d);
        @(negedge clk);
        host_wdata = d; host_cont = 1'b1; host_wr = 1'b0;
        @(negedge clk);
        host_cont = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic rd_word(input logic [15:0] base, output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(base + 16'(i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] s;
        cyc = 0;
        for (int i = 0; i < 100; i++) begin
            rd(STAT, s);
            if (s == 8'h01) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    // One addressed byte, then seven continue bytes ending on the command.
    task automatic stream(input logic [23:0] a, input logic [31:0] d, input logic [7:0] c);
        wr_reg(A0, a[7:0]);
        cont_wr(a[15:8]);
        cont_wr(a[23:16]);
        for (int i = 0; i < 4; i++) cont_wr(d[8*i +: 8]);
        cont_wr(c);
    endtask

    task automatic ram_read(input logic [23:0] a, output logic [31:0] w);
        int cyc;
        stream(a, 32'h0, 8'h01);
        wait_idle(cyc);
        rd_word(D0, w);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        int          cyc, zeros;
        logic [7:0]  samp [6];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset values
        for (int i = 0; i < 8; i++) begin
            rd(A0 + 16'(i), b);
            chk("R9 reset reg", {24'h0, b}, 32'h0);
        end
        rd(STAT, b); chk("R9 reset status", {24'h0, b}, 32'h01);

        // R3: pointer starts at the first address register
        cont_wr(8'hAA); cont_wr(8'hBB);
        rd(A0, b); chk("R3 first continue", {24'h0, b}, 32'hAA);
        rd(A1, b); chk("R3 second continue", {24'h0, b}, 32'hBB);

        // R10: addressed write wins; R3: pointer reloaded from it
        @(negedge clk);
        host_addr = D1; host_wdata = 8'h9C; host_wr = 1'b1; host_cont = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_cont = 1'b0;
        rd(D1, b); chk("R10 addressed byte", {24'h0, b}, 32'h9C);
        rd(A2, b); chk("R10 pointer target untouched", {24'h0, b}, 32'h00);
        cont_wr(8'h4E);
        rd(16'h2006, b); chk("R3 reload after addressed", {24'h0, b}, 32'h4E);

        // R2: unmapped addresses
        wr_reg(16'h2000, 8'hFF);
        wr_reg(16'h200A, 8'hFF);
        rd(16'h2000, b); chk("R2 below window", {24'h0, b}, 32'h0);
        rd(16'h200A, b); chk("R2 above window", {24'h0, b}, 32'h0);
        rd(16'h0000, b); chk("R2 far address", {24'h0, b}, 32'h0);
        rd(A0, b); chk("R2 no side write", {24'h0, b}, 32'hAA);
        cont_wr(8'h5D);
        rd(D3, b); chk("R2 pointer kept", {24'h0, b}, 32'h5D);

        // Vector table: write every word, then read each back
        for (int v = 0; v < NVEC; v++) begin
            stream(VEC[v][55:32], VEC[v][31:0], 8'h02);
            wait_idle(cyc);
            chk("R5 write completes", cyc, 32'd3);
        end
        for (int v = 0; v < NVEC; v++) begin
            ram_read(VEC[v][55:32], w);
            chk("R6 read data", w, VEC[v][31:0]);
            rd(A0, b); chk("R1 addr byte0", {24'h0, b}, {24'h0, VEC[v][39:32]});
            rd(CMD, b); chk("R8 command readback", {24'h0, b}, 32'h01);
        end

        // R5: outside the table
        stream(24'h000040, 32'hFFFF_FFFF, 8'h02);
        wait_idle(cyc);
        ram_read(24'h000000, w); chk("R5 no alias write", w, 32'hA5A5_0001);
        ram_read(24'h000040, w); chk("R5 out of table read", w, 32'h0);
        ram_read(24'h100000, w); chk("R5 high address read", w, 32'h0);

        // R7: exact busy window
        stream(24'h000007, 32'h0BAD_F00D, 8'h02);
        for (int i = 0; i < 6; i++) begin
            rd(STAT, samp[i]);
            @(negedge clk);
        end
        zeros = 0;
        for (int i = 0; i < 6; i++) if (samp[i] == 8'h00) zeros++;
        chk("R7 busy cycles", zeros, 32'd3);
        chk("R7 busy first", {24'h0, samp[0]}, 32'h00);
        chk("R7 idle after", {24'h0, samp[3]}, 32'h01);

        // R8: a write command during a read is ignored
        stream(24'h000007, 32'h1111_1111, 8'h01);
        wr_reg(CMD, 8'h02);
        wait_idle(cyc);
        rd(CMD, b); chk("R8 busy command dropped", {24'h0, b}, 32'h01);
        rd_word(D0, w); chk("R6 read result", w, 32'h0BAD_F00D);
        ram_read(24'h000007, w); chk("R8 table unchanged", w, 32'h0BAD_F00D);

        // R8: invalid code; R4: pointer holds at the command register
        wr_reg(D3, 8'h22);
        cont_wr(8'h05);
        rd(STAT, b); chk("R8 invalid code idle", {24'h0, b}, 32'h01);
        rd(CMD, b); chk("R8 invalid code kept", {24'h0, b}, 32'h01);
        cont_wr(8'h02);
        rd(STAT, b); chk("R4 saturated command starts", {24'h0, b}, 32'h00);
        rd(A0, b); chk("R4 no wrap", {24'h0, b}, 32'h07);
        wait_idle(cyc);

        // R9: reset during an access
        stream(24'h000008, 32'h2222_2222, 8'h02);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(STAT, b); chk("R9 reset ends access", {24'h0, b}, 32'h01);
        rd(CMD, b); chk("R9 reset command", {24'h0, b}, 32'h00);
        rd_word(D0, w); chk("R9 reset data", w, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule